// File: doc/BRIEF.md
# E1 to 24-Channel Backplane Mapper

This block takes received E1 frames, each made of 32 eight-bit time slots, and re-times them onto a serial backplane frame of 193 bit times. That frame opens with one framing bit, which is always 1, and then carries 24 eight-bit channels.

A 32-bit drop mask chooses which E1 slots to discard. The slots that remain fill the 24 backplane channels in ascending slot order. Channels that are left over carry the idle code FFh. A host writes the mask through a small byte-wide register port.

Incoming bytes arrive with a slot index and a frame-start strobe. Each complete E1 frame is stored in one half of a two-bank buffer while the other half is being serialised. At every output frame boundary the block takes up the newest complete frame and the current mask value. All logic runs on one clock, and the output advances only on a bit-enable strobe.

Top module: `e1_bp_mapper`

## Requirements
- R1: Bit position 0 of every output frame is driven to 1, and `framePulse` is high for exactly that bit time.
- R2: An output frame lasts 193 bit-enable strobes: the framing bit followed by 24 channels of 8 bits.
- R3: After reset the mask reads 00h, 00h, 00h, FFh at addresses 0 to 3, so E1 slots 0 to 23 appear unchanged in backplane channels 1 to 24.
- R4: Each unmasked slot is placed in the next free backplane channel, in ascending slot order. A slot whose mask bit is 1 never appears on `serOut`.
- R5: Mask byte address k covers slots 8k to 8k+7, and bit 0 of address 0 is slot 0. For example, bytes 01h, 00h, 01h, FCh drop slots 0 and 16 and keep 24 slots.
- R6: A mask write takes effect only at the next output frame boundary. The frame currently being sent keeps the old mapping.
- R7: If more than 24 slots are unmasked at a frame boundary, only the first 24 are carried and `overflow` is set. `overflow` stays set until reset.
- R8: If fewer than 24 slots are unmasked, the remaining channels carry FFh.
- R9: Each channel byte is sent MSB first.
- R10: If no new complete E1 frame has been captured since the previous boundary, all 24 channels of the output frame carry FFh.
- R11: `serOut` and `framePulse` change only on a clock edge where `bitEn` is high.
- R12: A frame is complete only when the byte for slot 31 arrives after a byte marked with `inFrameStart` (or that byte is itself marked). Bytes written without a frame start never reach the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | An E1 byte is present this cycle |
| inSlot | input | 5 | E1 slot index of the byte (0 to 31) |
| inData | input | 8 | E1 byte |
| inFrameStart | input | 1 | Marks the first byte of an E1 frame |
| regWe | input | 1 | Mask register write strobe |
| regAddr | input | 2 | Mask byte address |
| regWdata | input | 8 | Mask byte write data |
| regRdata | output | 8 | Mask byte read data at `regAddr` |
| bitEn | input | 1 | Advance the backplane by one bit time |
| serOut | output | 1 | Backplane serial data |
| framePulse | output | 1 | High during the framing bit |
| overflow | output | 1 | Sticky flag: more than 24 slots were unmasked |

## Verification
The hardest situations to reach from the ports are a mask write that lands in the middle of an output frame and a captured E1 frame that never completes. In both, the output must show no trace of the new input until the next boundary, or at all.

The stimulus covers both. It writes a new mask while a frame is half serialised, and it sends a full set of 32 bytes with no start marker. A behavioural model predicts every bit, so any early or leaked change shows up on the very clock where it happens. The bench also slows `bitEn` to one strobe in three, which exercises the hold behaviour between strobes.

// File: rtl/e1bp_pkg.sv
package e1bp_pkg;
  localparam int SLOT_NUM   = 32;
  localparam int CHAN_NUM   = 24;
  localparam int BYTE_W     = 8;
  localparam int SLOT_W     = $clog2(SLOT_NUM);
  localparam int MASK_BYTES = SLOT_NUM / BYTE_W;
  localparam int FRAME_LEN  = CHAN_NUM * BYTE_W + 1;
  localparam int POS_W      = $clog2(FRAME_LEN);
  localparam int BIT_W      = $clog2(BYTE_W);
  localparam int CHAN_W     = POS_W - BIT_W;
  localparam logic [SLOT_NUM-1:0] RESET_MASK = {{(SLOT_NUM-CHAN_NUM){1'b1}}, {CHAN_NUM{1'b0}}};

  typedef struct packed {
    logic              loadFrame;
    logic              shiftEn;
    logic              frameBit;
    logic [CHAN_W-1:0] chanIdx;
    logic [BIT_W-1:0]  bitIdx;
    logic              wrBank;
    logic              rdBank;
    logic              haveData;
  } ctrlStrobes_t;
endpackage

// File: rtl/e1bp_ctrl.sv
module e1bp_ctrl
  import e1bp_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              bitEn,
  input  logic              inValid,
  input  logic [SLOT_W-1:0] inSlot,
  input  logic              inFrameStart,
  output ctrlStrobes_t      ctl
);
  logic [POS_W-1:0] bitCnt;
  logic [POS_W-1:0] dataPos;
  logic wrBank, rdBank, lastBank, newAvail, started, haveData;
  logic capDone;

  // Complete frame: slot 31 arrives after (or together with) a start marker.
  assign capDone = inValid && (inSlot == SLOT_W'(SLOT_NUM - 1)) && (started || inFrameStart);

  always_comb begin
    dataPos       = bitCnt - 1'b1;
    ctl.frameBit  = (bitCnt == '0);
    ctl.loadFrame = bitEn && (bitCnt == '0);
    ctl.shiftEn   = bitEn;
    ctl.chanIdx   = dataPos[POS_W-1:BIT_W];
    ctl.bitIdx    = dataPos[BIT_W-1:0];
    ctl.wrBank    = wrBank;
    ctl.rdBank    = rdBank;
    ctl.haveData  = haveData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bitCnt   <= '0;
      wrBank   <= 1'b0;
      rdBank   <= 1'b0;
      lastBank <= 1'b0;
      newAvail <= 1'b0;
      started  <= 1'b0;
      haveData <= 1'b0;
    end else begin
      if (bitEn)
        bitCnt <= (bitCnt == POS_W'(FRAME_LEN - 1)) ? '0 : bitCnt + 1'b1;
      if (ctl.loadFrame) begin
        if (newAvail) begin
          rdBank   <= lastBank;
          haveData <= 1'b1;
          newAvail <= 1'b0;
        end else begin
          haveData <= 1'b0;
        end
      end
      if (inValid) begin
        if (capDone) started <= 1'b0;
        else if (inFrameStart) started <= 1'b1;
      end
      if (capDone) begin
        lastBank <= wrBank;
        wrBank   <= ~wrBank;
        newAvail <= 1'b1;
      end
    end
  end

  assert_cnt_range_R2: assert property (@(posedge clk) disable iff (!rstN)
    bitCnt < POS_W'(FRAME_LEN));

  assert_banks_apart_R10: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.loadFrame && newAvail) |=> (rdBank != wrBank));
endmodule

// File: rtl/e1bp_datapath.sv
module e1bp_datapath
  import e1bp_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      ctl,
  input  logic              inValid,
  input  logic [SLOT_W-1:0] inSlot,
  input  logic [BYTE_W-1:0] inData,
  input  logic              regWe,
  input  logic [1:0]        regAddr,
  input  logic [BYTE_W-1:0] regWdata,
  output logic [BYTE_W-1:0] regRdata,
  output logic              serOut,
  output logic              framePulse,
  output logic              overflow
);
  logic [BYTE_W-1:0]   maskByte [MASK_BYTES];
  logic [SLOT_NUM-1:0] maskReg;
  logic [SLOT_NUM-1:0] actMask;
  logic [BYTE_W-1:0]   bufMem [2][SLOT_NUM];
  logic [SLOT_W-1:0]   selSlot;
  logic                selFound;
  logic [BYTE_W-1:0]   curByte;
  logic                nextBit;
  int                  unmaskCnt;

  // One register per mask byte: address k holds slots 8k..8k+7.
  for (genvar b = 0; b < MASK_BYTES; b++) begin : g_maskByte
    always_ff @(posedge clk) begin
      if (!rstN) maskByte[b] <= RESET_MASK[b*BYTE_W +: BYTE_W];
      else if (regWe && (int'(regAddr) == b)) maskByte[b] <= regWdata;
    end
    assign maskReg[b*BYTE_W +: BYTE_W] = maskByte[b];
  end

  assign regRdata = maskByte[regAddr];

  always_ff @(posedge clk) begin
    if (inValid) bufMem[ctl.wrBank][inSlot] <= inData;
  end

  // Find the slot whose rank among unmasked slots equals the channel index.
  always_comb begin
    int rank;
    rank     = 0;
    selSlot  = '0;
    selFound = 1'b0;
    for (int s = 0; s < SLOT_NUM; s++) begin
      if (!actMask[s]) begin
        if (!selFound && rank == int'(ctl.chanIdx)) begin
          selSlot  = SLOT_W'(s);
          selFound = 1'b1;
        end
        rank = rank + 1;
      end
    end
  end

  always_comb begin
    unmaskCnt = $countones(~maskReg);
    curByte   = bufMem[ctl.rdBank][selSlot];
    if (ctl.frameBit) nextBit = 1'b1;
    else if (ctl.haveData && selFound) nextBit = curByte[BYTE_W - 1 - int'(ctl.bitIdx)];
    else nextBit = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      serOut     <= 1'b1;
      framePulse <= 1'b0;
      actMask    <= RESET_MASK;
      overflow   <= 1'b0;
    end else begin
      if (ctl.shiftEn) begin
        serOut     <= nextBit;
        framePulse <= ctl.frameBit;
      end
      if (ctl.loadFrame) begin
        actMask <= maskReg;
        if (unmaskCnt > CHAN_NUM) overflow <= 1'b1;
      end
    end
  end

  assert_frame_bit_R1: assert property (@(posedge clk) disable iff (!rstN)
    framePulse |-> serOut);

  assert_hold_R11: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.shiftEn |=> ($stable(serOut) && $stable(framePulse)));

  assert_mask_stable_R6: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.loadFrame |=> $stable(actMask));

  assert_overflow_sticky_R7: assert property (@(posedge clk) disable iff (!rstN)
    overflow |=> overflow);

  assert_idle_fill_R8: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.shiftEn && !ctl.frameBit && !selFound) |=> serOut);
endmodule

// File: rtl/e1_bp_mapper.sv
module e1_bp_mapper
  import e1bp_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [SLOT_W-1:0] inSlot,
  input  logic [BYTE_W-1:0] inData,
  input  logic              inFrameStart,
  input  logic              regWe,
  input  logic [1:0]        regAddr,
  input  logic [BYTE_W-1:0] regWdata,
  output logic [BYTE_W-1:0] regRdata,
  input  logic              bitEn,
  output logic              serOut,
  output logic              framePulse,
  output logic              overflow
);
  ctrlStrobes_t ctl;

  e1bp_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .bitEn(bitEn), .inValid(inValid),
    .inSlot(inSlot), .inFrameStart(inFrameStart), .ctl(ctl)
  );

  e1bp_datapath u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .inValid(inValid), .inSlot(inSlot),
    .inData(inData), .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata),
    .regRdata(regRdata), .serOut(serOut), .framePulse(framePulse),
    .overflow(overflow)
  );
endmodule

// File: tb/tb_e1_bp_mapper.sv
module tb_e1_bp_mapper;
  logic clk = 1'b0, rstN = 1'b0;
  logic inValid = 1'b0, inFrameStart = 1'b0, regWe = 1'b0, bitEn = 1'b0;
  logic [4:0] inSlot = '0;
  logic [7:0] inData = '0, regWdata = '0, regRdata;
  logic [1:0] regAddr = '0;
  logic serOut, framePulse, overflow;

  e1_bp_mapper dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inSlot(inSlot), .inData(inData),
    .inFrameStart(inFrameStart), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .bitEn(bitEn), .serOut(serOut),
    .framePulse(framePulse), .overflow(overflow)
  );

  always #5 clk = ~clk;

  int total = 0, bad = 0, cyc = 0, divCnt = 0;
  bit fastMode = 1, checking = 0, done = 0;
  string curReq = "R3";

  // Behavioural reference model
  int mPos;
  bit [31:0] mRegMask, mActMask;
  logic [7:0] capArr [32], pendArr [32], actArr [32];
  bit mNewAvail, mHave, mStarted, mOvf, expSer, expPulse;
  int mMap[$];
  string serReq;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp, string what);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h time=%0t", req, what, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rstN) begin
      mPos = 0; mRegMask = 32'hFF00_0000; mActMask = 32'hFF00_0000;
      mNewAvail = 0; mHave = 0; mStarted = 0; mOvf = 0;
      expSer = 1; expPulse = 0; serReq = "R1";
    end else begin
      if (bitEn) begin
        if (mPos == 0) begin
          expSer = 1; expPulse = 1; serReq = "R1";
          mActMask = mRegMask;
          mMap.delete();
          for (int s = 0; s < 32; s++) if (!mActMask[s]) mMap.push_back(s);
          if (mMap.size() > 24) mOvf = 1;
          if (mNewAvail) begin actArr = pendArr; mHave = 1; mNewAvail = 0; end
          else mHave = 0;
        end else begin
          int ch, b;
          ch = (mPos - 1) / 8;
          b = 7 - (mPos - 1) % 8;
          expPulse = 0; serReq = curReq;
          if (mHave && ch < mMap.size()) expSer = actArr[mMap[ch]][b];
          else expSer = 1;
        end
        mPos = (mPos == 192) ? 0 : mPos + 1;
      end
      if (inValid) begin
        capArr[inSlot] = inData;
        if (inSlot == 31 && (mStarted || inFrameStart)) begin
          pendArr = capArr; mNewAvail = 1; mStarted = 0;
        end else if (inFrameStart) mStarted = 1;
      end
      if (regWe) mRegMask[regAddr*8 +: 8] = regWdata;
    end
  end

  // bit-enable pattern
  always @(negedge clk) begin
    divCnt = (divCnt + 1) % 3;
    bitEn = fastMode || (divCnt == 0);
  end

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    cyc++;
    if (rstN && checking) begin
      chk(serReq, 32'(serOut), 32'(expSer), "serOut");
      chk("R2", 32'(framePulse), 32'(expPulse), "framePulse");
      chk("R7", 32'(overflow), 32'(mOvf), "overflow");
    end
    if (cyc > 150000 && !done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog R2 actual=%0d expected=%0d", cyc, 150000);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic waitStart();
    do @(negedge clk); while (mPos != 1);
  endtask

  task automatic sendFrame(int seed, bit withStart);
    for (int s = 0; s < 32; s++) begin
      @(negedge clk);
      inValid = 1; inSlot = 5'(s); inData = 8'(seed * 37 + s * 13 + 5);
      inFrameStart = withStart && (s == 0);
    end
    @(negedge clk);
    inValid = 0; inFrameStart = 0;
  endtask

  task automatic writeMask(logic [7:0] b0, logic [7:0] b1, logic [7:0] b2, logic [7:0] b3);
    logic [7:0] v [4];
    v[0] = b0; v[1] = b1; v[2] = b2; v[3] = b3;
    for (int a = 0; a < 4; a++) begin
      @(negedge clk);
      regWe = 1; regAddr = 2'(a); regWdata = v[a];
    end
    @(negedge clk);
    regWe = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // reset state (R3, R5 byte layout)
    for (int a = 0; a < 4; a++) begin
      regAddr = 2'(a);
      #1 chk("R3", 32'(regRdata), (a == 3) ? 32'hFF : 32'h00, "reset mask byte");
    end
    chk("R1", 32'(serOut), 32'h1, "reset serOut");
    chk("R2", 32'(framePulse), 32'h0, "reset framePulse");
    chk("R7", 32'(overflow), 32'h0, "reset overflow");
    @(negedge clk);
    rstN = 1; checking = 1;

    // default mapping, MSB first
    waitStart(); sendFrame(1, 1);
    waitStart(); curReq = "R9"; sendFrame(2, 1);
    // drop slots 0 and 16
    writeMask(8'h01, 8'h00, 8'h01, 8'hFC);
    regAddr = 2'd3; #1 chk("R5", 32'(regRdata), 32'hFC, "mask readback");
    waitStart(); curReq = "R3"; sendFrame(3, 1);
    // mask change in the middle of an output frame
    waitStart(); curReq = "R5";
    sendFrame(4, 1);
    repeat (60) @(negedge clk);
    curReq = "R6";
    writeMask(8'h00, 8'h00, 8'hF0, 8'hFF);
    // fewer than 24 unmasked
    waitStart(); curReq = "R8"; sendFrame(5, 1);
    // scattered mask keeps 24
    writeMask(8'h55, 8'h00, 8'h0F, 8'h00);
    waitStart(); curReq = "R4"; sendFrame(6, 1);
    // all unmasked: overflow
    writeMask(8'h00, 8'h00, 8'h00, 8'h00);
    waitStart(); curReq = "R7"; sendFrame(7, 1);
    repeat (3) @(negedge clk);
    chk("R7", 32'(overflow), 32'h1, "overflow set");
    writeMask(8'h00, 8'h00, 8'h00, 8'hFF);
    waitStart(); curReq = "R7";
    repeat (3) @(negedge clk);
    chk("R7", 32'(overflow), 32'h1, "overflow sticky");
    // no new frame -> idle
    waitStart(); curReq = "R10";
    // frame without a start marker is never taken
    sendFrame(8, 0);
    waitStart(); curReq = "R12";
    // slow bit enable
    fastMode = 0;
    sendFrame(9, 1);
    waitStart(); curReq = "R11"; sendFrame(10, 1);
    waitStart(); curReq = "R11";
    waitStart();
    repeat (4) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule